// File: doc/BRIEF.md
# Dual-Block SAD Motion Search Engine

This engine runs an exhaustive block-matching search for two reference blocks at once. The two N×N blocks sit one above the other in the current frame. Both are scored against the same search window taken from the previous frame, so each search pel crosses the input port only once and serves both blocks. The cost of a candidate displacement is the sum of absolute differences (SAD) over the block. The engine reports, for each of the two blocks, the displacement with the smallest SAD as a signed motion vector, together with that SAD.

Pels arrive on one valid/ready stream. A job first loads reference pels into a shift chain, then pushes the search window through a second shift chain. It then walks every candidate origin, one per clock. An array of N×N paired processing elements forms an accumulation chain that scores block A and block B in the same cycle. While the engine is working through candidates the input stalls. A one-cycle done pulse marks the results. The job can also step one block down a column: the upper unit takes over the reference data that the lower unit already holds, and only the new lower block is loaded.

Top module: `dual_ref_me`

## Requirements
- R1: After reset, in_ready is 1, done is 0, and every motion vector and SAD output is 0.
- R2: Each transfer happens on a clock where in_valid and in_ready are both 1. A normal job takes 2·N² reference pels (block A in raster order r·N+c, then block B in the same order) and then (N+7)·(2N+7) search pels in raster order, row r and column c at index r·(N+7)+c. Clocks with in_valid low do not advance the load.
- R3: The SAD of a candidate is the sum of |ref − search| over all N² positions. With N=4 its largest value, 4080, is reported exactly, with no wrap.
- R4: Candidate origin (cx,cy), with cx and cy in 0..7, places block A over window rows cy..cy+N−1 and block B over rows cy+N..cy+2N−1, at columns cx..cx+N−1. The reported vector is x = cx−4 and y = cy−3, as 4-bit two's complement.
- R5: Candidates are visited with cy in the outer loop and cx in the inner loop. When SADs are equal, the first one visited wins.
- R6: done is high for exactly one cycle. It comes 64 clocks after the edge that accepts the last search pel. in_ready is 0 between that edge and done, and it is 1 again in the cycle done is high.
- R7: The vector and SAD outputs change only in a cycle where done is high, and they hold their values until the next done.
- R8: If hand_over is 1 with the first reference pel of a job, block A takes the block B data of the previous job. Only N² pels are then taken as the new block B, starting with that pel.
- R9: in_valid asserted while the engine is scoring candidates is ignored. The next job's results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pel on in_pel is offered |
| in_pel | input | 8 | Reference or search pel, unsigned |
| hand_over | input | 1 | With first reference pel: A takes previous B |
| in_ready | output | 1 | Engine accepts a pel this cycle |
| done | output | 1 | One-cycle result strobe |
| mv_a_x | output | 4 | Block A horizontal vector, signed |
| mv_a_y | output | 4 | Block A vertical vector, signed |
| sad_a | output | 12 | Block A minimum SAD |
| mv_b_x | output | 4 | Block B horizontal vector, signed |
| mv_b_y | output | 4 | Block B vertical vector, signed |
| sad_b | output | 12 | Block B minimum SAD |

## Verification
A pel is accepted on the rising edge where it is offered with in_ready high. The results are then due exactly 64 edges after the edge that accepts the last search pel. The bench samples every cycle on the falling edge: it expects done low and in_ready low for the 64 samples after that edge, and then done, in_ready and all six results together on the 65th sample. On each of those cycles it keeps in_valid high with junk data, so the ignore rule is tested. The expected vectors come from a behavioural full search in integers over the same pel arrays the bench sent. After each done it watches the outputs for some idle cycles to confirm they hold.

// File: rtl/me_pkg.sv
package me_pkg;
    typedef enum logic [1:0] {
        ST_REF  = 2'd0,
        ST_SRCH = 2'd1,
        ST_SCAN = 2'd2
    } me_state_e;
endpackage

// File: rtl/me_pe.sv
// Paired processing element: two subtracters sharing the chain position,
// each adding its absolute difference to the partial sum from upstream.
module me_pe #(
    parameter int PEL_W = 8,
    parameter int SUM_W = 12
) (
    input  logic [PEL_W-1:0] ref_a_i,
    input  logic [PEL_W-1:0] ref_b_i,
    input  logic [PEL_W-1:0] srch_a_i,
    input  logic [PEL_W-1:0] srch_b_i,
    input  logic [SUM_W-1:0] acc_a_i,
    input  logic [SUM_W-1:0] acc_b_i,
    output logic [SUM_W-1:0] acc_a_o,
    output logic [SUM_W-1:0] acc_b_o
);
    logic [PEL_W-1:0] diff_a, diff_b;

    always_comb begin
        diff_a  = (ref_a_i > srch_a_i) ? (ref_a_i - srch_a_i) : (srch_a_i - ref_a_i);
        diff_b  = (ref_b_i > srch_b_i) ? (ref_b_i - srch_b_i) : (srch_b_i - ref_b_i);
        acc_a_o = acc_a_i + SUM_W'(diff_a);
        acc_b_o = acc_b_i + SUM_W'(diff_b);
    end
endmodule

// File: rtl/me_best_track.sv
// Keeps the running minimum; strict compare keeps the earliest candidate on ties.
module me_best_track #(
    parameter int SUM_W = 12,
    parameter int CX_W  = 3,
    parameter int CY_W  = 3
) (
    input  logic             first_i,
    input  logic [SUM_W-1:0] sad_i,
    input  logic [CX_W-1:0]  cx_i,
    input  logic [CY_W-1:0]  cy_i,
    input  logic [SUM_W-1:0] best_sad_i,
    input  logic [CX_W-1:0]  best_cx_i,
    input  logic [CY_W-1:0]  best_cy_i,
    output logic [SUM_W-1:0] nxt_sad_o,
    output logic [CX_W-1:0]  nxt_cx_o,
    output logic [CY_W-1:0]  nxt_cy_o
);
    logic take;

    always_comb begin
        take      = first_i || (sad_i < best_sad_i);
        nxt_sad_o = take ? sad_i : best_sad_i;
        nxt_cx_o  = take ? cx_i  : best_cx_i;
        nxt_cy_o  = take ? cy_i  : best_cy_i;
    end
endmodule

// File: rtl/dual_ref_me.sv
module dual_ref_me #(
    parameter int PEL_W = 8,
    parameter int N     = 4,
    parameter int LEFT  = 4,
    parameter int RIGHT = 3,
    parameter int DOWN  = 3,
    parameter int UP    = 4,
    parameter int SUM_W = 12,
    parameter int MV_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [PEL_W-1:0]        in_pel,
    input  logic                    hand_over,
    output logic                    in_ready,
    output logic                    done,
    output logic signed [MV_W-1:0]  mv_a_x,
    output logic signed [MV_W-1:0]  mv_a_y,
    output logic [SUM_W-1:0]        sad_a,
    output logic signed [MV_W-1:0]  mv_b_x,
    output logic signed [MV_W-1:0]  mv_b_y,
    output logic [SUM_W-1:0]        sad_b
);
    import me_pkg::*;

    localparam int NN     = N * N;
    localparam int RNG_H  = LEFT + RIGHT + 1;
    localparam int RNG_V  = DOWN + UP + 1;
    localparam int WIN_W  = N + RNG_H - 1;
    localparam int WIN_H  = 2 * N + RNG_V - 1;
    localparam int WIN_SZ = WIN_W * WIN_H;
    localparam int RC_W   = $clog2(2 * NN + 1);
    localparam int WC_W   = $clog2(WIN_SZ);
    localparam int WI_W   = $clog2(WIN_SZ);
    localparam int CX_W   = $clog2(RNG_H);
    localparam int CY_W   = $clog2(RNG_V);

    typedef struct packed {
        me_state_e               st;
        logic                    ho;
        logic [RC_W-1:0]         rc;
        logic [WC_W-1:0]         wc;
        logic [CX_W-1:0]         cx;
        logic [CY_W-1:0]         cy;
        logic [SUM_W-1:0]        ba_sad;
        logic [CX_W-1:0]         ba_cx;
        logic [CY_W-1:0]         ba_cy;
        logic [SUM_W-1:0]        bb_sad;
        logic [CX_W-1:0]         bb_cx;
        logic [CY_W-1:0]         bb_cy;
        logic                    done;
        logic signed [MV_W-1:0]  oax;
        logic signed [MV_W-1:0]  oay;
        logic [SUM_W-1:0]        oas;
        logic signed [MV_W-1:0]  obx;
        logic signed [MV_W-1:0]  oby;
        logic [SUM_W-1:0]        obs;
    } ctl_t;

    ctl_t             c_q, c_d;
    logic [PEL_W-1:0] refa_q [NN];
    logic [PEL_W-1:0] refa_d [NN];
    logic [PEL_W-1:0] refb_q [NN];
    logic [PEL_W-1:0] refb_d [NN];
    logic [PEL_W-1:0] win_q  [WIN_SZ];
    logic [PEL_W-1:0] win_d  [WIN_SZ];

    logic [SUM_W-1:0] chain_a [NN+1];
    logic [SUM_W-1:0] chain_b [NN+1];

    logic             xfer, ho_now, first_cand, last_cx, last_cy;
    logic [RC_W:0]    rc_nxt;
    logic [SUM_W-1:0] na_sad, nb_sad;
    logic [CX_W-1:0]  na_cx, nb_cx;
    logic [CY_W-1:0]  na_cy, nb_cy;

    assign in_ready = (c_q.st != ST_SCAN);
    assign xfer     = in_valid && in_ready;

    // Accumulation chain of paired elements: position k = r*N + c.
    assign chain_a[0] = '0;
    assign chain_b[0] = '0;
    for (genvar k = 0; k < NN; k++) begin : g_pe
        localparam int R = k / N;
        localparam int C = k % N;
        logic [WI_W-1:0] ia, ib;
        assign ia = WI_W'((int'(c_q.cy) + R) * WIN_W + int'(c_q.cx) + C);
        assign ib = WI_W'((int'(c_q.cy) + R + N) * WIN_W + int'(c_q.cx) + C);
        me_pe #(.PEL_W(PEL_W), .SUM_W(SUM_W)) u_pe (
            .ref_a_i  (refa_q[k]),
            .ref_b_i  (refb_q[k]),
            .srch_a_i (win_q[ia]),
            .srch_b_i (win_q[ib]),
            .acc_a_i  (chain_a[k]),
            .acc_b_i  (chain_b[k]),
            .acc_a_o  (chain_a[k+1]),
            .acc_b_o  (chain_b[k+1])
        );
    end

    assign first_cand = (c_q.cx == '0) && (c_q.cy == '0);

    me_best_track #(.SUM_W(SUM_W), .CX_W(CX_W), .CY_W(CY_W)) u_best_a (
        .first_i    (first_cand),
        .sad_i      (chain_a[NN]),
        .cx_i       (c_q.cx),
        .cy_i       (c_q.cy),
        .best_sad_i (c_q.ba_sad),
        .best_cx_i  (c_q.ba_cx),
        .best_cy_i  (c_q.ba_cy),
        .nxt_sad_o  (na_sad),
        .nxt_cx_o   (na_cx),
        .nxt_cy_o   (na_cy)
    );

    me_best_track #(.SUM_W(SUM_W), .CX_W(CX_W), .CY_W(CY_W)) u_best_b (
        .first_i    (first_cand),
        .sad_i      (chain_b[NN]),
        .cx_i       (c_q.cx),
        .cy_i       (c_q.cy),
        .best_sad_i (c_q.bb_sad),
        .best_cx_i  (c_q.bb_cx),
        .best_cy_i  (c_q.bb_cy),
        .nxt_sad_o  (nb_sad),
        .nxt_cx_o   (nb_cx),
        .nxt_cy_o   (nb_cy)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        refa_d   = refa_q;
        refb_d   = refb_q;
        win_d    = win_q;
        ho_now   = (c_q.rc == '0) ? hand_over : c_q.ho;
        rc_nxt   = '0;
        last_cx  = (c_q.cx == CX_W'(RNG_H - 1));
        last_cy  = (c_q.cy == CY_W'(RNG_V - 1));

        case (c_q.st)
            ST_REF: begin
                if (xfer) begin
                    c_d.ho = ho_now;
                    if ((c_q.rc == '0) && hand_over) begin
                        refa_d = refb_q;
                        rc_nxt = (RC_W+1)'(NN + 1);
                    end else begin
                        rc_nxt = {1'b0, c_q.rc} + 1'b1;
                        if (!ho_now) begin
                            for (int i = 0; i < NN - 1; i++) refa_d[i] = refa_q[i+1];
                            refa_d[NN-1] = refb_q[0];
                        end
                    end
                    for (int i = 0; i < NN - 1; i++) refb_d[i] = refb_q[i+1];
                    refb_d[NN-1] = in_pel;
                    if (rc_nxt == (RC_W+1)'(2 * NN)) begin
                        c_d.rc = '0;
                        c_d.st = ST_SRCH;
                    end else begin
                        c_d.rc = rc_nxt[RC_W-1:0];
                    end
                end
            end
            ST_SRCH: begin
                if (xfer) begin
                    for (int i = 0; i < WIN_SZ - 1; i++) win_d[i] = win_q[i+1];
                    win_d[WIN_SZ-1] = in_pel;
                    if (c_q.wc == WC_W'(WIN_SZ - 1)) begin
                        c_d.wc = '0;
                        c_d.cx = '0;
                        c_d.cy = '0;
                        c_d.st = ST_SCAN;
                    end else begin
                        c_d.wc = c_q.wc + 1'b1;
                    end
                end
            end
            default: begin
                c_d.ba_sad = na_sad;
                c_d.ba_cx  = na_cx;
                c_d.ba_cy  = na_cy;
                c_d.bb_sad = nb_sad;
                c_d.bb_cx  = nb_cx;
                c_d.bb_cy  = nb_cy;
                if (last_cx) begin
                    c_d.cx = '0;
                    if (last_cy) begin
                        c_d.cy   = '0;
                        c_d.st   = ST_REF;
                        c_d.done = 1'b1;
                        c_d.oax  = MV_W'(int'(na_cx) - LEFT);
                        c_d.oay  = MV_W'(int'(na_cy) - DOWN);
                        c_d.oas  = na_sad;
                        c_d.obx  = MV_W'(int'(nb_cx) - LEFT);
                        c_d.oby  = MV_W'(int'(nb_cy) - DOWN);
                        c_d.obs  = nb_sad;
                    end else begin
                        c_d.cy = c_q.cy + 1'b1;
                    end
                end else begin
                    c_d.cx = c_q.cx + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_REF;
            for (int i = 0; i < NN; i++) begin
                refa_q[i] <= '0;
                refb_q[i] <= '0;
            end
            for (int i = 0; i < WIN_SZ; i++) win_q[i] <= '0;
        end else begin
            c_q    <= c_d;
            refa_q <= refa_d;
            refb_q <= refb_d;
            win_q  <= win_d;
        end
    end

    assign done   = c_q.done;
    assign mv_a_x = c_q.oax;
    assign mv_a_y = c_q.oay;
    assign sad_a  = c_q.oas;
    assign mv_b_x = c_q.obx;
    assign mv_b_y = c_q.oby;
    assign sad_b  = c_q.obs;
endmodule

// File: rtl/me_check.sv
module me_check #(
    parameter int PEL_W = 8,
    parameter int N     = 4,
    parameter int LEFT  = 4,
    parameter int RIGHT = 3,
    parameter int DOWN  = 3,
    parameter int UP    = 4,
    parameter int SUM_W = 12,
    parameter int MV_W  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_ready,
    input logic                   done,
    input logic signed [MV_W-1:0] mv_a_x,
    input logic signed [MV_W-1:0] mv_a_y,
    input logic [SUM_W-1:0]       sad_a,
    input logic signed [MV_W-1:0] mv_b_x,
    input logic signed [MV_W-1:0] mv_b_y,
    input logic [SUM_W-1:0]       sad_b
);
    localparam int MAX_SAD = N * N * ((1 << PEL_W) - 1);

    // R6: result strobe lasts one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: input reopens together with the strobe
    a_r6_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready);

    // R7: results move only with the strobe
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({mv_a_x, mv_a_y, sad_a, mv_b_x, mv_b_y, sad_b}));

    // R3: reported sums stay within the exact bound
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(sad_a) <= MAX_SAD) && (int'(sad_b) <= MAX_SAD));

    // R4: vectors inside the search range
    a_r4_mv_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(mv_a_x) >= -LEFT) && (int'(mv_a_x) <= RIGHT)
              && (int'(mv_a_y) >= -DOWN) && (int'(mv_a_y) <= UP)
              && (int'(mv_b_x) >= -LEFT) && (int'(mv_b_x) <= RIGHT)
              && (int'(mv_b_y) >= -DOWN) && (int'(mv_b_y) <= UP));
endmodule

bind dual_ref_me me_check #(
    .PEL_W(PEL_W), .N(N), .LEFT(LEFT), .RIGHT(RIGHT),
    .DOWN(DOWN), .UP(UP), .SUM_W(SUM_W), .MV_W(MV_W)
) u_me_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .done     (done),
    .mv_a_x   (mv_a_x),
    .mv_a_y   (mv_a_y),
    .sad_a    (sad_a),
    .mv_b_x   (mv_b_x),
    .mv_b_y   (mv_b_y),
    .sad_b    (sad_b)
);

// File: tb/dual_ref_me_test.sv
`timescale 1ns/1ps
module dual_ref_me_test;
    localparam int NN     = 16;
    localparam int WW     = 11;
    localparam int WH     = 15;
    localparam int WSZ    = WW * WH;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_pel = '0;
    logic              hand_over = 1'b0;
    logic              in_ready, done;
    logic signed [3:0] mv_a_x, mv_a_y, mv_b_x, mv_b_y;
    logic [11:0]       sad_a, sad_b;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    int ra [NN];
    int rb [NN];
    int wn [WSZ];

    always #5 clk = ~clk;

    dual_ref_me uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pel(in_pel),
        .hand_over(hand_over), .in_ready(in_ready), .done(done),
        .mv_a_x(mv_a_x), .mv_a_y(mv_a_y), .sad_a(sad_a),
        .mv_b_x(mv_b_x), .mv_b_y(mv_b_y), .sad_b(sad_b)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural full search over the arrays the bench sent.
    task automatic model(output int ax, output int ay, output int as,
                         output int bx, output int by, output int bs);
        as = -1; bs = -1; ax = 0; ay = 0; bx = 0; by = 0;
        for (int cy = 0; cy < 8; cy++) begin
            for (int cx = 0; cx < 8; cx++) begin
                int sa = 0;
                int sb = 0;
                for (int r = 0; r < 4; r++) begin
                    for (int c = 0; c < 4; c++) begin
                        int da = ra[r*4+c] - wn[(cy+r)*WW + cx + c];
                        int db = rb[r*4+c] - wn[(cy+r+4)*WW + cx + c];
                        sa += (da < 0) ? -da : da;
                        sb += (db < 0) ? -db : db;
                    end
                end
                if (as < 0 || sa < as) begin as = sa; ax = cx - 4; ay = cy - 3; end
                if (bs < 0 || sb < bs) begin bs = sb; bx = cx - 4; by = cy - 3; end
            end
        end
    endtask

    task automatic push(int v, bit ho, int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_pel    = 8'hEE;
            hand_over = 1'b1;
        end
        @(negedge clk);
        chk(in_ready == 1'b1, "R2", "in_ready during load", int'(in_ready), 1);
        in_valid  = 1'b1;
        in_pel    = 8'(v);
        hand_over = ho;
        @(posedge clk);
    endtask

    task automatic run_job(bit ho, int gap, string tag);
        int ax, ay, as, bx, by, bs;
        if (!ho) for (int i = 0; i < NN; i++) push(ra[i], 1'b0, gap);
        for (int i = 0; i < NN; i++) push(rb[i], (i == 0) ? ho : 1'b0, gap);
        for (int i = 0; i < WSZ; i++) push(wn[i], 1'b0, (i % 37 == 5) ? gap : 0);
        model(ax, ay, as, bx, by, bs);
        // R6/R9: cycle-by-cycle check while junk is offered with in_valid high
        for (int k = 0; k <= 64; k++) begin
            @(negedge clk);
            if (k < 64) begin
                chk(done == 1'b0, "R6", "done early", int'(done), 0);
                chk(in_ready == 1'b0, "R6", "in_ready while scoring", int'(in_ready), 0);
                in_valid = 1'b1;
                in_pel   = 8'(k * 7);
            end else begin
                chk(done == 1'b1, "R6", "done at cycle 64", int'(done), 1);
                chk(in_ready == 1'b1, "R6", "in_ready with done", int'(in_ready), 1);
                in_valid = 1'b0;
                chk(int'(mv_a_x) == ax, tag, "mv_a_x", int'(mv_a_x), ax);
                chk(int'(mv_a_y) == ay, tag, "mv_a_y", int'(mv_a_y), ay);
                chk(int'(sad_a)  == as, tag, "sad_a",  int'(sad_a),  as);
                chk(int'(mv_b_x) == bx, tag, "mv_b_x", int'(mv_b_x), bx);
                chk(int'(mv_b_y) == by, tag, "mv_b_y", int'(mv_b_y), by);
                chk(int'(sad_b)  == bs, tag, "sad_b",  int'(sad_b),  bs);
            end
            if (k < 64) @(posedge clk);
        end
        // R6 pulse width and R7 hold
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(done == 1'b0, "R6", "done one cycle", int'(done), 0);
            chk(int'(sad_a) == as && int'(mv_b_x) == bx, "R7", "outputs hold",
                int'(sad_a), as);
        end
    endtask

    task automatic fill_rand(int lim);
        for (int i = 0; i < NN; i++) begin
            ra[i] = int'($urandom_range(lim));
            rb[i] = int'($urandom_range(lim));
        end
        for (int i = 0; i < WSZ; i++) wn[i] = int'($urandom_range(lim));
    endtask

    task automatic plant(bit blk_b, int cx, int cy);
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                wn[(cy + r + (blk_b ? 4 : 0))*WW + cx + c] = blk_b ? rb[r*4+c] : ra[r*4+c];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
        chk(sad_a == 0 && sad_b == 0 && mv_a_x == 0 && mv_b_y == 0, "R1",
            "outputs in reset", int'(sad_a), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && done == 1'b0, "R1", "after release", int'(in_ready), 1);

        // R4: planted exact matches at distinct origins, block B at the bottom-left corner
        fill_rand(255);
        plant(1'b0, 6, 2);
        plant(1'b1, 0, 7);
        run_job(1'b0, 0, "R4");
        chk(int'(sad_a) == 0 && int'(mv_a_x) == 2 && int'(mv_a_y) == -1, "R4",
            "A planted at (+2,-1)", int'(mv_a_x), 2);
        chk(int'(sad_b) == 0 && int'(mv_b_x) == -4 && int'(mv_b_y) == 4, "R4",
            "B planted at (-4,+4)", int'(mv_b_y), 4);

        // R5: all candidates tie, first in scan order wins
        for (int i = 0; i < NN; i++) begin ra[i] = 9; rb[i] = 9; end
        for (int i = 0; i < WSZ; i++) wn[i] = 9;
        run_job(1'b0, 1, "R5");
        chk(int'(mv_a_x) == -4 && int'(mv_a_y) == -3, "R5", "tie keeps first",
            int'(mv_a_x), -4);

        // R3: largest sum without wrap
        for (int i = 0; i < NN; i++) begin ra[i] = 255; rb[i] = 255; end
        for (int i = 0; i < WSZ; i++) wn[i] = 0;
        run_job(1'b0, 0, "R3");
        chk(int'(sad_a) == 4080 && int'(sad_b) == 4080, "R3", "max sad",
            int'(sad_a), 4080);

        // R8: hand-over; A takes the previous B (all 255), new B with stalls (R2)
        for (int i = 0; i < NN; i++) begin
            ra[i] = rb[i];
            rb[i] = int'($urandom_range(255));
        end
        for (int i = 0; i < WSZ; i++) wn[i] = int'($urandom_range(255));
        plant(1'b1, 3, 5);
        wn[0] = 250;
        run_job(1'b1, 2, "R8");
        chk(int'(sad_b) == 0 && int'(mv_b_x) == -1 && int'(mv_b_y) == 2, "R8",
            "new B found", int'(mv_b_x), -1);

        // R2/R5: small-range random pels, many ties
        for (int j = 0; j < 3; j++) begin
            fill_rand(3);
            run_job(1'b0, j, "R5");
        end
        // R2: wide-range random with stalls
        fill_rand(255);
        run_job(1'b0, 3, "R2");

        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule